// File: doc/BRIEF.md
# Per-Channel Offset and Gain Correction Pipeline

This block sits behind a multi-channel converter and corrects every raw 24-bit signed sample before it leaves the chip. Each channel owns a signed offset coefficient and an unsigned gain coefficient. The block first removes the channel's offset from the incoming sample, then scales the difference by the channel's gain. A sample arrives with a channel tag and a valid strobe. The corrected value comes out two cycles later with the same tag. The correction is always in force and cannot be bypassed.

The coefficients are loaded through a narrow register write port. Each 24-bit coefficient is split over two 16-bit writes: a high part and a low part. A new coefficient only takes effect when its low part is written, so the datapath never uses a half-updated value. The coefficients are volatile. Every reset restores the identity transform, which is zero offset and unity gain.

Top module: `calcorr_top`

## Requirements
- R1: After reset, and before any coefficient write, every output sample equals its input sample bit for bit on every channel.
- R2: The channel's offset, a 24-bit two's complement value, is subtracted from the sample at 25-bit width, so the difference never wraps.
- R3: The gain is an unsigned 1.23 fixed-point value. Code 0x000000 gives an output of zero, 0x800000 gives unity, and 0xFFFFFF gives 2 − 2^-23.
- R4: The product of difference and gain is shifted right by 23 bits and rounded half-up: exact halves round toward plus infinity.
- R5: A result above 0x7FFFFF saturates to 0x7FFFFF. A result below −0x800000 saturates to 0x800000.
- R6: Each channel's coefficients apply only to samples tagged with that channel.
- R7: The write address is {channel, kind, part}. The kind bit is 0 for offset and 1 for gain. The part bit is 0 for the high part and 1 for the low part. A high-part write carries coefficient bits [23:8] in wr_data[15:0]. A low-part write carries bits [7:0] in wr_data[15:8], and wr_data[7:0] is ignored.
- R8: A high-part write alone leaves the coefficient in use unchanged. The pending value is committed at the clock edge of the matching low-part write, and samples entering after that edge use it.
- R9: out_valid follows in_valid exactly two cycles later, and out_ch equals the in_ch of that sample. Samples may be presented on back-to-back cycles.
- R10: Reset returns every coefficient to zero offset and unity gain, including coefficients written before the reset.
- R11: The sign of the output follows the sign of the offset-corrected difference. A non-negative difference never yields a negative output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Coefficient register write strobe |
| wr_addr_i | input | CH_W+2 | {channel, kind, part} register address |
| wr_data_i | input | 16 | Register write data |
| in_valid_i | input | 1 | Input sample valid |
| in_ch_i | input | CH_W | Input channel tag |
| in_data_i | input | 24 | Raw two's complement sample |
| out_valid_o | output | 1 | Corrected sample valid |
| out_ch_o | output | CH_W | Channel tag of the corrected sample |
| out_data_o | output | 24 | Corrected, rounded, saturated sample |

## Verification
The bench builds the block with its defaults: four channels, 24-bit data and a 16-bit register port. With these values, full-scale inputs combined with opposite-signed offsets drive the 25-bit difference past both saturation rails. The smallest gain code, 1, places the rounding boundary at inputs of ±2^22, so the half-up rule is checked right at its boundary. Four channels also make it possible to check per-channel independence and a back-to-back burst that walks every tag through the pipeline.

// File: rtl/calcorr_pkg.sv
package calcorr_pkg;

    // Coefficient kind and register part, as decoded from the two low address bits
    typedef enum logic {
        KIND_OFFSET = 1'b0,
        KIND_GAIN   = 1'b1
    } coef_kind_e;

    typedef enum logic {
        PART_HIGH = 1'b0,
        PART_LOW  = 1'b1
    } coef_part_e;

    // Unity gain code for a coefficient of the given width (1.(w-1) format)
    function automatic logic [63:0] unity_code(input int w);
        return 64'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/calcorr_coef_bank.sv
module calcorr_coef_bank
    import calcorr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 24,
    parameter int REG_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [REG_W-1:0]                 wr_data_i,
    output logic [NUM_CH-1:0][DATA_W-1:0]    off_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]    gain_o
);

    localparam int LOW_W = DATA_W - REG_W;
    localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(unity_code(DATA_W));

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] off;
        logic [NUM_CH-1:0][DATA_W-1:0] gain;
        logic [NUM_CH-1:0][REG_W-1:0]  off_hi;
        logic [NUM_CH-1:0][REG_W-1:0]  gain_hi;
    } bank_t;

    function automatic bank_t reset_bank();
        bank_t b;
        for (int c = 0; c < NUM_CH; c++) begin
            b.off[c]     = '0;
            b.gain[c]    = GAIN_ONE;
            b.off_hi[c]  = '0;
            b.gain_hi[c] = GAIN_ONE[DATA_W-1:LOW_W];
        end
        return b;
    endfunction

    bank_t bank_d, bank_q;

    logic [CH_W-1:0] sel_ch;
    coef_kind_e      sel_kind;
    coef_part_e      sel_part;

    assign sel_ch   = wr_addr_i[ADDR_W-1:2];
    assign sel_kind = coef_kind_e'(wr_addr_i[1]);
    assign sel_part = coef_part_e'(wr_addr_i[0]);

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && (int'(sel_ch) < NUM_CH)) begin
            unique case ({sel_kind, sel_part})
                {KIND_OFFSET, PART_HIGH}: bank_d.off_hi[sel_ch]  = wr_data_i;
                {KIND_GAIN,   PART_HIGH}: bank_d.gain_hi[sel_ch] = wr_data_i;
                {KIND_OFFSET, PART_LOW}:  bank_d.off[sel_ch] =
                    {bank_q.off_hi[sel_ch], wr_data_i[REG_W-1 -: LOW_W]};
                default:                  bank_d.gain[sel_ch] =
                    {bank_q.gain_hi[sel_ch], wr_data_i[REG_W-1 -: LOW_W]};
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bank_q <= reset_bank();
        else         bank_q <= bank_d;
    end

    assign off_o  = bank_q.off;
    assign gain_o = bank_q.gain;

    // R8
    hi_write_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_addr_i[0]) |=> ($stable(bank_q.off) && $stable(bank_q.gain)));

endmodule

// File: rtl/calcorr_arith.sv
module calcorr_arith #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 24,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_CH-1:0][DATA_W-1:0] off_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] gain_i,
    input  logic                          in_valid_i,
    input  logic [CH_W-1:0]               in_ch_i,
    input  logic [DATA_W-1:0]             in_data_i,
    output logic                          out_valid_o,
    output logic [CH_W-1:0]               out_ch_o,
    output logic [DATA_W-1:0]             out_data_o
);

    localparam int DIFF_W = DATA_W + 1;
    localparam int FRAC   = DATA_W - 1;
    localparam int PROD_W = 2 * DIFF_W;

    localparam logic signed [PROD_W-1:0] RND =
        {{(PROD_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [PROD_W-1:0] SAT_HI =
        {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SAT_LO =
        {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic              s1_valid;
        logic [CH_W-1:0]   s1_ch;
        logic [DIFF_W-1:0] s1_diff;
        logic [DATA_W-1:0] s1_gain;
        logic              o_valid;
        logic [CH_W-1:0]   o_ch;
        logic [DATA_W-1:0] o_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [DIFF_W-1:0] x_ext, off_ext;
    logic signed [PROD_W-1:0] diff_ext, gain_ext, prod, shifted;

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: offset removal at 25 bits, coefficient capture
        x_ext   = $signed({in_data_i[DATA_W-1], in_data_i});
        off_ext = $signed({off_i[in_ch_i][DATA_W-1], off_i[in_ch_i]});
        pipe_d.s1_valid = in_valid_i;
        pipe_d.s1_ch    = in_ch_i;
        pipe_d.s1_diff  = x_ext - off_ext;
        pipe_d.s1_gain  = gain_i[in_ch_i];

        // stage 2: scale, round half-up, saturate
        diff_ext = $signed({{(PROD_W-DIFF_W){pipe_q.s1_diff[DIFF_W-1]}}, pipe_q.s1_diff});
        gain_ext = $signed({{(PROD_W-DATA_W){1'b0}}, pipe_q.s1_gain});
        prod     = diff_ext * gain_ext;
        shifted  = (prod + RND) >>> FRAC;
        pipe_d.o_valid = pipe_q.s1_valid;
        pipe_d.o_ch    = pipe_q.s1_ch;
        if (shifted > SAT_HI)      pipe_d.o_data = SAT_HI[DATA_W-1:0];
        else if (shifted < SAT_LO) pipe_d.o_data = SAT_LO[DATA_W-1:0];
        else                       pipe_d.o_data = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign out_valid_o = pipe_q.o_valid;
    assign out_ch_o    = pipe_q.o_ch;
    assign out_data_o  = pipe_q.o_data;

    // cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] age_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni)             age_q <= '0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    // R9
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

    // R9
    tag_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((age_q == 2'd2) && out_valid_o) |-> (out_ch_o == $past(in_ch_i, 2)));

    // R3
    zero_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_q.s1_valid && (pipe_q.s1_gain == '0)) |=> (out_data_o == '0));

    // R5
    sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_q.s1_valid && !pipe_q.s1_diff[DIFF_W-1] && pipe_q.s1_diff[DIFF_W-2]
         && pipe_q.s1_gain[DATA_W-1]) |=> (out_data_o == SAT_HI[DATA_W-1:0]));

    // R5
    sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_q.s1_valid && pipe_q.s1_diff[DIFF_W-1] && !pipe_q.s1_diff[DIFF_W-2]
         && pipe_q.s1_gain[DATA_W-1]) |=> (out_data_o == SAT_LO[DATA_W-1:0]));

    // R11
    sign_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_q.s1_valid && !pipe_q.s1_diff[DIFF_W-1]) |=> !out_data_o[DATA_W-1]);

endmodule

// File: rtl/calcorr_top.sv
module calcorr_top #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 24,
    parameter int REG_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              in_valid_i,
    input  logic [CH_W-1:0]   in_ch_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_valid_o,
    output logic [CH_W-1:0]   out_ch_o,
    output logic [DATA_W-1:0] out_data_o
);

    logic [NUM_CH-1:0][DATA_W-1:0] off_w;
    logic [NUM_CH-1:0][DATA_W-1:0] gain_w;

    calcorr_coef_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) i_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .off_o     (off_w),
        .gain_o    (gain_w)
    );

    calcorr_arith #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) i_arith (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .off_i       (off_w),
        .gain_i      (gain_w),
        .in_valid_i  (in_valid_i),
        .in_ch_i     (in_ch_i),
        .in_data_i   (in_data_i),
        .out_valid_o (out_valid_o),
        .out_ch_o    (out_ch_o),
        .out_data_o  (out_data_o)
    );

endmodule

// File: tb/test_calcorr_top.sv
module test_calcorr_top;

    localparam int  CLK_NS   = 10;
    localparam int  WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_ch = '0;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic [1:0]  out_ch;
    logic [23:0] out_data;

    calcorr_top i_calcorr_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .in_valid_i  (in_valid),
        .in_ch_i     (in_ch),
        .in_data_i   (in_data),
        .out_valid_o (out_valid),
        .out_ch_o    (out_ch),
        .out_data_o  (out_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          ch;
        logic [23:0] data;
        int          due;
        string       req;
    } exp_t;

    exp_t sb[$];

    // bench-side coefficient model
    longint off_m[4], gain_m[4];
    logic [15:0] off_hi_m[4], gain_hi_m[4];

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [23:0] model(input logic [23:0] x, input longint o, input longint g);
        longint d, p, r;
        d = sx(x) - o;
        p = d * g;
        r = (p + 64'sd4194304) >>> 23;
        if (r > 64'sd8388607)  r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r[23:0];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            off_m[c] = 0; gain_m[c] = 64'h800000;
            off_hi_m[c] = 16'h0000; gain_hi_m[c] = 16'h8000;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one register write, address {ch, kind, part}
    task automatic wr(input int ch, input bit gain, input bit low, input logic [15:0] d);
        @(negedge clk);
        in_valid = 1'b0;
        wr_en    = 1'b1;
        wr_addr  = {2'(ch), gain, low};
        wr_data  = d;
        if (!low) begin
            if (gain) gain_hi_m[ch] = d; else off_hi_m[ch] = d;
        end else begin
            if (gain) gain_m[ch] = longint'({gain_hi_m[ch], d[15:8]});
            else      off_m[ch]  = sx({off_hi_m[ch], d[15:8]});
        end
    endtask

    task automatic set_coef(input int ch, input bit gain, input logic [23:0] v);
        wr(ch, gain, 1'b0, v[23:8]);
        wr(ch, gain, 1'b1, {v[7:0], 8'h5A});
    endtask

    task automatic send(input int ch, input logic [23:0] x, input string req);
        exp_t e;
        @(negedge clk);
        wr_en    = 1'b0;
        in_valid = 1'b1;
        in_ch    = 2'(ch);
        in_data  = x;
        e.ch   = ch;
        e.data = model(x, off_m[ch], gain_m[ch]);
        e.due  = cyc + 2;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            in_valid = 1'b0;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.data, e.req, "data", out_data, e.data);
                check(int'(out_ch) == e.ch, "R9", "tag", out_ch, e.ch);
                check(cyc == e.due, "R9", "latency", cyc, e.due);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;

        // R1 identity on defaults
        send(0, 24'h000000, "R1");
        send(1, 24'h7FFFFF, "R1");
        send(2, 24'h800000, "R1");
        send(3, 24'h123456, "R1");
        send(0, 24'hFEDCBA, "R1");
        idle(3);

        // R8 high part alone does nothing
        wr(1, 1'b1, 1'b0, 16'h4000);
        send(1, 24'h100000, "R8");
        idle(3);
        // R7 low part commits, low byte of wr_data ignored
        wr(1, 1'b1, 1'b1, 16'h00FF);
        send(1, 24'h100000, "R7");
        send(1, 24'h000003, "R7");
        idle(3);

        // R2 offsets, positive and negative
        set_coef(0, 1'b0, 24'h000100);
        send(0, 24'h000050, "R2");
        set_coef(0, 1'b0, 24'hFFFFFB);
        send(0, 24'h000003, "R2");
        // R6 other channels unaffected
        send(2, 24'h000050, "R6");
        send(3, 24'hABCDEF, "R6");
        idle(3);

        // R3 gain codes
        set_coef(2, 1'b1, 24'h000000);
        send(2, 24'h654321, "R3");
        set_coef(3, 1'b1, 24'hFFFFFF);
        send(3, 24'h100000, "R3");
        idle(3);

        // R4 rounding with gain code 1
        set_coef(2, 1'b1, 24'h000001);
        send(2, 24'h400000, "R4");
        send(2, 24'hC00000, "R4");
        send(2, 24'h3FFFFF, "R4");
        send(2, 24'hBFFFFF, "R4");
        idle(3);

        // R5 saturation, both rails
        set_coef(0, 1'b0, 24'h800000);
        send(0, 24'h7FFFFF, "R5");
        set_coef(0, 1'b0, 24'h7FFFFF);
        send(0, 24'h800000, "R5");
        send(3, 24'h500000, "R5");
        send(3, 24'hB00000, "R5");
        // R11 sign follows difference
        send(3, 24'h000001, "R11");
        send(3, 24'hFFFFFF, "R11");
        idle(3);

        // R9 back-to-back burst over all tags
        for (int i = 0; i < 8; i++) send(i % 4, 24'(i * 24'h031337), "R9");
        idle(4);

        // R10 reset restores identity
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        idle(2);
        rst_n = 1'b1;
        send(0, 24'h2468AC, "R10");
        send(1, 24'h100000, "R10");
        send(2, 24'h400000, "R10");
        send(3, 24'h800001, "R10");
        idle(4);

        check(sb.size() == 0, "R9", "outstanding samples", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule